// File: doc/BRIEF.md
# Flash ROM In-System Programming Port

This block lets a host reprogram a parallel character flash ROM in place, through a byte-wide host bus qualified by a chip-select strobe. In normal operation the ROM address bus follows the video fetch address and the ROM output enable is active. While the programming mode is active, a host-loaded address register drives the ROM address bus instead. The ROM data pins are driven, output enable is held off, and each host data byte produces one write-enable pulse.

The host enters programming mode by writing a control byte while it holds the device reset line. Releasing that line ends the mode. A 17-bit ROM address is loaded as three tagged chunks. A chunk code in bits [7:6] of the address byte selects which part is replaced, and its payload sits in the low bits. A data byte then starts the write. The host sends any flash unlock sequences as ordinary packets. Because the ROM reports no completion, the host waits long enough between packets.

Top module: `flash_prog_port`

## Requirements
- R1: After the synchronous reset `rst`, the outputs are `prog_mode`=0, `rom_we_n`=1, `rom_oe_n`=0 and `rom_dq_en`=0, `rom_addr` equals `vid_addr`, and the address register is 0.
- R2: A control transfer (`host_sel`=2'b10) sets `prog_mode` to `host_data[0]` only while `host_reset` is high. A control transfer made while `host_reset` is low leaves `prog_mode` at 0.
- R3: After `host_reset` goes low, `prog_mode` is 0 by the third rising clock edge and stays 0.
- R4: While `prog_mode`=1, `rom_addr` equals the address register, `rom_oe_n`=1 and `rom_dq_en`=1. While `prog_mode`=0, `rom_addr` equals `vid_addr`.
- R5: An address transfer (`host_sel`=2'b00) uses the chunk code in `host_data[7:6]`. Code 00 loads address bits 5:0 from `host_data[5:0]`. Code 01 loads bits 11:6 from `host_data[5:0]`. Code 10 loads bits 16:12 from `host_data[4:0]`. All other address bits are kept.
- R6: An address transfer with chunk code 11 leaves the address register unchanged.
- R7: A data transfer (`host_sel`=2'b01) in programming mode puts the byte on `rom_dq`. One clock later, `rom_we_n` goes low for exactly WE_CYCLES clocks (default 3). During that pulse `rom_oe_n`=1, and `rom_addr` and `rom_dq` are stable.
- R8: A transfer is taken only on a rising edge of `host_cs`, with the bus value present at that moment. It takes effect at the third rising clock edge after the strobe rises. Holding the strobe high or letting it fall does nothing.
- R9: Outside programming mode, data transfers give no write pulse and address transfers leave the address register unchanged.
- R10: A control transfer with `host_data[0]`=0 while `host_reset` is high clears `prog_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| host_reset | input | 1 | Device reset line from the host, asynchronous, high = held in reset |
| host_cs | input | 1 | Host transfer strobe, asynchronous, acts on its rising edge |
| host_sel | input | 2 | Transfer kind: 00 address, 01 data, 10 control, 11 none |
| host_data | input | 8 | Host data byte |
| vid_addr | input | 17 | Video fetch address for normal operation |
| prog_mode | output | 1 | Programming mode active |
| rom_addr | output | 17 | ROM address bus |
| rom_dq | output | 8 | Data toward the ROM |
| rom_dq_en | output | 1 | Drive enable for the ROM data pins |
| rom_we_n | output | 1 | ROM write enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |

## Verification
A wrong address register shows on `rom_addr` at the third clock edge after the strobe, but only while programming mode is on. Loads made in normal mode are therefore checked by re-entering the mode and reading the bus. A stuck or wrongly gated mode bit shows at once as the video address, or its absence, on `rom_addr` and as a flipped `rom_oe_n`. A faulty write sequencer shows within a few clocks as a missing pulse, a pulse of the wrong length or start cycle, or a data or address value that changes while `rom_we_n` is low.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int LO_W   = 6;
    localparam int MID_W  = 6;
    localparam int HI_W   = ADDR_W - LO_W - MID_W;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_ADDR = 2'b00,
        SEL_DATA = 2'b01,
        SEL_CTRL = 2'b10,
        SEL_NONE = 2'b11
    } host_sel_e;

    typedef enum logic [1:0] {
        CH_LO   = 2'b00,
        CH_MID  = 2'b01,
        CH_HI   = 2'b10,
        CH_SKIP = 2'b11
    } chunk_e;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_SETUP,
        WS_PULSE,
        WS_HOLD
    } wr_state_e;

    typedef struct packed {
        host_sel_e          sel;
        logic [DATA_W-1:0]  data;
    } host_xfer_t;

    // Replace the address slice that the byte's tag selects.
    function automatic logic [ADDR_W-1:0] merge_chunk(
        input logic [ADDR_W-1:0] cur,
        input logic [DATA_W-1:0] b
    );
        logic [ADDR_W-1:0] r;
        r = cur;
        case (chunk_e'(b[DATA_W-1 -: 2]))
            CH_LO:   r[LO_W-1:0]                = b[LO_W-1:0];
            CH_MID:  r[LO_W+MID_W-1:LO_W]       = b[MID_W-1:0];
            CH_HI:   r[ADDR_W-1:LO_W+MID_W]     = b[HI_W-1:0];
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fp_sync.sv
module fp_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fp_strobe_det.sv
module fp_strobe_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic host_cs,
    input  logic host_reset,
    output logic cs_rise,
    output logic reset_s
);
    logic [1:0] raw;
    logic [1:0] synced;
    logic       cs_prev;

    assign raw = {host_reset, host_cs};

    fp_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    always_ff @(posedge clk) begin
        if (rst) cs_prev <= 1'b0;
        else     cs_prev <= synced[0];
    end

    assign cs_rise = synced[0] & ~cs_prev;
    assign reset_s = synced[1];
endmodule

// File: rtl/fp_addr_asm.sv
module fp_addr_asm
    import flash_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] chunk_byte,
    output logic [ADDR_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst)       addr_q <= '0;
        else if (load) addr_q <= merge_chunk(addr_q, chunk_byte);
    end
endmodule

// File: rtl/fp_write_seq.sv
module fp_write_seq
    import flash_prog_pkg::*;
#(
    parameter int WE_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] dq,
    output logic              we_n,
    output logic              busy
);
    localparam int CNT_W = (WE_CYCLES > 1) ? $clog2(WE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WE_CYCLES - 1);

    wr_state_e        state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WS_IDLE;
            cnt   <= '0;
            dq    <= '0;
        end else begin
            case (state)
                WS_IDLE: if (start) begin
                    dq    <= data_in;
                    state <= WS_SETUP;
                end
                WS_SETUP: begin
                    cnt   <= CNT_LAST;
                    state <= WS_PULSE;
                end
                WS_PULSE: begin
                    if (cnt == '0) state <= WS_HOLD;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    assign we_n = (state != WS_PULSE);
    assign busy = (state != WS_IDLE);
endmodule

// File: rtl/flash_prog_port.sv
module flash_prog_port
    import flash_prog_pkg::*;
#(
    parameter int WE_CYCLES   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_reset,
    input  logic              host_cs,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [DATA_W-1:0] host_data,
    input  logic [ADDR_W-1:0] vid_addr,
    output logic              prog_mode,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [DATA_W-1:0] rom_dq,
    output logic              rom_dq_en,
    output logic              rom_we_n,
    output logic              rom_oe_n
);
    host_xfer_t        xfer;
    logic              cs_rise;
    logic              reset_s;
    logic              wr_busy;
    logic [ADDR_W-1:0] addr_q;
    logic              addr_load;
    logic              wr_start;

    assign xfer = '{sel: host_sel_e'(host_sel), data: host_data};

    fp_strobe_det #(.STAGES(SYNC_STAGES)) u_strobe (
        .clk        (clk),
        .rst        (rst),
        .host_cs    (host_cs),
        .host_reset (host_reset),
        .cs_rise    (cs_rise),
        .reset_s    (reset_s)
    );

    // Mode bit: writable only under host reset, dropped when it is released.
    always_ff @(posedge clk) begin
        if (rst || !reset_s)                         prog_mode <= 1'b0;
        else if (cs_rise && xfer.sel == SEL_CTRL)    prog_mode <= xfer.data[0];
    end

    assign addr_load = cs_rise && prog_mode && (xfer.sel == SEL_ADDR);
    assign wr_start  = cs_rise && prog_mode && (xfer.sel == SEL_DATA) && !wr_busy;

    fp_addr_asm u_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (addr_load),
        .chunk_byte (xfer.data),
        .addr_q     (addr_q)
    );

    fp_write_seq #(.WE_CYCLES(WE_CYCLES)) u_wr (
        .clk     (clk),
        .rst     (rst),
        .start   (wr_start),
        .data_in (xfer.data),
        .dq      (rom_dq),
        .we_n    (rom_we_n),
        .busy    (wr_busy)
    );

    assign rom_addr  = prog_mode ? addr_q : vid_addr;
    assign rom_dq_en = prog_mode;
    assign rom_oe_n  = prog_mode | ~rom_we_n;
endmodule

// File: rtl/fp_checker.sv
module fp_checker
    import flash_prog_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_reset,
    input logic [SEL_W-1:0]  host_sel,
    input logic [1:0]        chunk_code,
    input logic              prog_mode,
    input logic [ADDR_W-1:0] rom_addr,
    input logic [DATA_W-1:0] rom_dq,
    input logic              rom_we_n,
    input logic              rom_oe_n,
    input logic              cs_rise,
    input logic [ADDR_W-1:0] addr_q
);
    // R7: write and output enables never active together
    p_we_excl_oe_r7: assert property (@(posedge clk) disable iff (rst)
        !rom_we_n |-> rom_oe_n);

    // R7: address and data held during the write pulse
    p_we_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (!rom_we_n && $past(!rom_we_n)) |-> ($stable(rom_addr) && $stable(rom_dq)));

    // R3: released host reset clears the mode
    p_mode_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (!host_reset && $past(!host_reset) && $past(!host_reset, 2)) |=> !prog_mode);

    // R2: entry only when host reset was seen through the synchronizer
    p_mode_entry_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_mode) |-> $past(host_reset, 3));

    // R6: skip code keeps the address register
    p_chunk_skip_r6: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && host_sel == SEL_ADDR && chunk_code == 2'b11) |=> $stable(addr_q));
endmodule

bind flash_prog_port fp_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_reset (host_reset),
    .host_sel   (host_sel),
    .chunk_code (host_data[7:6]),
    .prog_mode  (prog_mode),
    .rom_addr   (rom_addr),
    .rom_dq     (rom_dq),
    .rom_we_n   (rom_we_n),
    .rom_oe_n   (rom_oe_n),
    .cs_rise    (cs_rise),
    .addr_q     (addr_q)
);

// File: tb/tb_flash_prog_port.sv
module tb_flash_prog_port;
    localparam int WE_CYCLES = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_reset = 1'b0;
    logic        host_cs = 1'b0;
    logic [1:0]  host_sel = 2'b11;
    logic [7:0]  host_data = 8'h00;
    logic [16:0] vid_addr = 17'h0ABCD;
    logic        prog_mode;
    logic [16:0] rom_addr;
    logic [7:0]  rom_dq;
    logic        rom_dq_en;
    logic        rom_we_n;
    logic        rom_oe_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    flash_prog_port #(.WE_CYCLES(WE_CYCLES)) dut (
        .clk(clk), .rst(rst), .host_reset(host_reset), .host_cs(host_cs),
        .host_sel(host_sel), .host_data(host_data), .vid_addr(vid_addr),
        .prog_mode(prog_mode), .rom_addr(rom_addr), .rom_dq(rom_dq),
        .rom_dq_en(rom_dq_en), .rom_we_n(rom_we_n), .rom_oe_n(rom_oe_n)
    );

    typedef struct packed {
        logic [7:0]  b;
        logic [16:0] exp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{8'h2A, 17'h0002A},   // R5 code 00
        '{8'h55, 17'h0056A},   // R5 code 01
        '{8'h9F, 17'h1F56A},   // R5 code 10
        '{8'hFF, 17'h1F56A},   // R6 skip
        '{8'h3F, 17'h1F57F},   // R5 code 00 again
        '{8'hB5, 17'h1557F},   // R5 code 10, payload bit 5 unused
        '{8'h40, 17'h1503F},   // R5 code 01 clears mid slice
        '{8'hC7, 17'h1503F}    // R6 skip
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_sel  = sel;
        host_data = d;
        host_cs   = 1'b1;
        repeat (4) @(negedge clk);
        host_cs = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Data transfer; records where and how long the write pulse is.
    task automatic data_pulse(input logic [7:0] d, input logic [16:0] exp_addr,
                              output int first, output int lows, output int bad);
        first = 0; lows = 0; bad = 0;
        @(negedge clk);
        host_sel  = 2'b01;
        host_data = d;
        host_cs   = 1'b1;
        for (int i = 1; i <= 14; i++) begin
            @(negedge clk);
            if (!rom_we_n) begin
                lows++;
                if (first == 0) first = i;
                if (rom_dq !== d || rom_oe_n !== 1'b1 || rom_addr !== exp_addr) bad++;
            end
            if (i == 4) host_cs = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int first, lows, bad;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 prog_mode", 32'(prog_mode), 32'd0);
        check("R1 we_n/oe_n/dq_en", {29'd0, rom_we_n, rom_oe_n, rom_dq_en}, {29'd0, 3'b100});
        check("R1 rom_addr follows video", 32'(rom_addr), 32'h0ABCD);
        vid_addr = 17'h12345;
        #1 check("R4 video address in normal mode", 32'(rom_addr), 32'h12345);

        // R2 control write without host reset is ignored
        xfer(2'b10, 8'h01);
        check("R2 mode write outside host reset", 32'(prog_mode), 32'd0);

        // R2 enter programming mode
        host_reset = 1'b1;
        repeat (3) @(negedge clk);
        xfer(2'b10, 8'h01);
        check("R2 mode set under host reset", 32'(prog_mode), 32'd1);
        check("R4 oe_n/dq_en in prog mode", {30'd0, rom_oe_n, rom_dq_en}, 32'b11);
        check("R1 address register reset value", 32'(rom_addr), 32'h0);

        // R5/R6 vector walk
        for (int i = 0; i < 8; i++) begin
            xfer(2'b00, VEC[i].b);
            check($sformatf("R5/R6 vector %0d", i), 32'(rom_addr), 32'(VEC[i].exp));
        end

        // R8 latency: no change at second edge, change at third
        @(negedge clk);
        host_sel = 2'b00; host_data = 8'h15; host_cs = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 not yet applied", 32'(rom_addr), 32'h1503F);
        @(negedge clk);
        check("R8 applied at third edge", 32'(rom_addr), 32'h15015);
        // R8 change bus while strobe held, then drop it: nothing happens
        host_data = 8'h3E;
        repeat (3) @(negedge clk);
        host_cs = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 held/falling strobe ignored", 32'(rom_addr), 32'h15015);

        // R7 write pulse
        data_pulse(8'hA5, 17'h15015, first, lows, bad);
        check("R7 pulse start cycle", 32'(first), 32'd4);
        check("R7 pulse length", 32'(lows), 32'(WE_CYCLES));
        check("R7 dq/oe/addr during pulse", 32'(bad), 32'd0);
        check("R7 dq holds byte", 32'(rom_dq), 32'hA5);
        data_pulse(8'h3C, 17'h15015, first, lows, bad);
        check("R7 second pulse length", 32'(lows), 32'(WE_CYCLES));
        check("R7 second pulse data", 32'(bad), 32'd0);

        // R10 clear the mode while host reset is held
        xfer(2'b10, 8'h00);
        check("R10 mode cleared", 32'(prog_mode), 32'd0);
        check("R4 video address back", 32'(rom_addr), 32'h12345);

        // R9 transfers outside mode
        data_pulse(8'h77, 17'h12345, first, lows, bad);
        check("R9 no pulse outside mode", 32'(lows), 32'd0);
        xfer(2'b00, 8'h00);
        xfer(2'b10, 8'h01);
        check("R9 address register untouched", 32'(rom_addr), 32'h15015);

        // R3 release host reset
        @(negedge clk);
        host_reset = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 mode still on before sync", 32'(prog_mode), 32'd1);
        @(negedge clk);
        check("R3 mode cleared on release", 32'(prog_mode), 32'd0);
        repeat (5) @(negedge clk);
        check("R3 mode stays off", 32'(prog_mode), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule